// File: doc/BRIEF.md
# Keyed Reset Watchdog Timer

This block is a 32-bit down-counting watchdog for a chip's slow always-on domain. A slow tick enable runs it, nominally at 32768 Hz, so a load of 1638 gives an expiry about 50 ms after start. Software programs a reload value as two 16-bit halves, then starts the counter. It can re-arm the counter at any time by setting a "take new load" bit. When the count runs out, the block either raises a reset request that stays high until the block itself is reset, or it sets a sticky expiry flag and starts a new period.

Writes to the load halves and to the control register take effect only after a 16-bit key has been written to the key register. Any other value written there closes the gate again. Reads are never blocked.

The sequencing core is a four-state machine:
- **ST_IDLE** (stopped): moves to ST_ARM when the run bit and the new-load bit are both set, or to ST_COUNT when only the run bit is set.
- **ST_ARM** (one cycle): copies the load value into the counter, clears the new-load bit, and returns to ST_COUNT, or to ST_IDLE if the run bit has gone.
- **ST_COUNT**: returns to ST_IDLE when the run bit clears. It goes to ST_ARM when the new-load bit is set. It goes to ST_FIRED on an expiring tick with reset enabled. Otherwise it stays and counts.
- **ST_FIRED**: holds the reset request and is left only by the block's reset.

Top module: `guarded_wdt`

## Requirements
- R1: After reset, the key register reads 1 (locked), both load halves read 0, the control register reads 0, the counter reads 0 and `rst_req` is low.
- R2: Writing 0xE551 to byte offset 0x20 unlocks the block. Writing any other value there, for example 0x1AAE, locks it. Reading offset 0x20 returns 1 in bit 0 while locked and 0 while unlocked.
- R3: While the block is locked, writes to offsets 0x0 (load bits 15:0), 0x4 (load bits 31:16) and 0x8 (control) have no effect. Reads of those offsets still return the stored contents.
- R4: The control register at offset 0x8 holds the following bits. All other bits read 0.
  - Bit 1: run.
  - Bit 2: take new load.
  - Bit 3: reset on expiry.
  - Bit 4: sticky expiry flag.
- R5: A write to the control register that leaves run set and sets bit 2 loads the counter with {load high, load low} within two cycles. After that, bit 2 reads back as 0.
- R6: While running, each cycle with `tick` high lowers the counter by one. While run is clear, ticks leave the counter unchanged, and setting run again without bit 2 resumes from the held value. The counter reads at offset 0xC (bits 15:0) and offset 0x10 (bits 31:16).
- R7: With bit 3 set, the tick that takes the counter from 1 to 0 (or that arrives at 0) raises `rst_req` in the next cycle. `rst_req` then stays high, whatever is written, until `rst_n` is asserted.
- R8: With bit 3 clear, an expiring tick sets bit 4 of the control register and reloads the counter from the load value, and counting continues. Writing 1 to bit 4 while unlocked clears the flag.
- R9: The counter borrows from its upper half into its lower half: 0x0001_0000 becomes 0x0000_FFFF after one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow tick enable, one cycle wide |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of a read strobe |
| rst_req | output | 1 | System reset request, held once raised |

## Verification
A wrong state in the machine shows at the ports quickly:
- A missed move into ST_ARM leaves the counter readback at its old value, and bit 2 of the control register still reads 1, within two cycles of the control write.
- A mistaken stay in ST_COUNT after run is cleared shows as a counter that still moves on the next tick.
- A missed entry into ST_FIRED, or an early exit from it, shows on `rst_req` one cycle after the expiring tick, or on any later cycle before reset.

A wrong lock state shows at the next read of offset 0x20, or as a load or control value that changes or fails to change after a write.

// File: rtl/guarded_wdt_pkg.sv
package guarded_wdt_pkg;

    // Byte offsets of the register window
    localparam int OFS_LOAD_LO = 'h00;
    localparam int OFS_LOAD_HI = 'h04;
    localparam int OFS_CTRL    = 'h08;
    localparam int OFS_CNT_LO  = 'h0C;
    localparam int OFS_CNT_HI  = 'h10;
    localparam int OFS_KEY     = 'h20;

    // Control register bit positions
    localparam int CB_RUN   = 1;
    localparam int CB_NEW   = 2;
    localparam int CB_RSTEN = 3;
    localparam int CB_FLAG  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2,
        ST_FIRED = 2'd3
    } wdt_state_e;

endpackage

// File: rtl/gwdt_regs.sv
module gwdt_regs
    import guarded_wdt_pkg::*;
#(
    parameter int                HALF_W     = 16,
    parameter int                ADDR_W     = 6,
    parameter logic [HALF_W-1:0] UNLOCK_KEY = 16'hE551
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [HALF_W-1:0]     bus_wdata,
    output logic [HALF_W-1:0]     bus_rdata,
    input  logic [2*HALF_W-1:0]   cnt_val,
    input  logic                  load_done,
    input  logic                  expire_ev,
    output logic                  run,
    output logic                  newload,
    output logic                  rst_en,
    output logic [2*HALF_W-1:0]   load_val
);

    localparam int CNT_W = 2 * HALF_W;

    logic              locked_q;
    logic              flag_q;
    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] hi_q;
    logic              wr;
    logic              wr_lo;
    logic              wr_hi;
    logic              wr_ctrl;
    logic              wr_key;

    assign wr      = bus_sel & bus_we;
    assign wr_key  = wr & (bus_addr == ADDR_W'(OFS_KEY));
    assign wr_lo   = wr & ~locked_q & (bus_addr == ADDR_W'(OFS_LOAD_LO));
    assign wr_hi   = wr & ~locked_q & (bus_addr == ADDR_W'(OFS_LOAD_HI));
    assign wr_ctrl = wr & ~locked_q & (bus_addr == ADDR_W'(OFS_CTRL));

    assign load_val = {hi_q, lo_q};

    // Key gate: closed out of reset, opened only by the exact key
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= 1'b1;
        end else if (wr_key) begin
            locked_q <= (bus_wdata != UNLOCK_KEY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo) lo_q <= bus_wdata;
            if (wr_hi) hi_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run     <= 1'b0;
            rst_en  <= 1'b0;
            newload <= 1'b0;
        end else if (wr_ctrl) begin
            run     <= bus_wdata[CB_RUN];
            rst_en  <= bus_wdata[CB_RSTEN];
            newload <= bus_wdata[CB_NEW];
        end else if (load_done) begin
            newload <= 1'b0;
        end
    end

    // Sticky expiry flag: set wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire_ev && !rst_en) begin
            flag_q <= 1'b1;
        end else if (wr_ctrl && bus_wdata[CB_FLAG]) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                ADDR_W'(OFS_LOAD_LO): bus_rdata = lo_q;
                ADDR_W'(OFS_LOAD_HI): bus_rdata = hi_q;
                ADDR_W'(OFS_CNT_LO):  bus_rdata = cnt_val[HALF_W-1:0];
                ADDR_W'(OFS_CNT_HI):  bus_rdata = cnt_val[CNT_W-1:HALF_W];
                ADDR_W'(OFS_KEY):     bus_rdata = HALF_W'(locked_q);
                ADDR_W'(OFS_CTRL): begin
                    bus_rdata[CB_RUN]   = run;
                    bus_rdata[CB_NEW]   = newload;
                    bus_rdata[CB_RSTEN] = rst_en;
                    bus_rdata[CB_FLAG]  = flag_q;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // R3: a locked write leaves load halves and control settings untouched
    p_locked_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && wr) |=> ($stable(lo_q) && $stable(hi_q) && $stable(run) && $stable(rst_en)));

    // R2: the exact key opens the gate on the next cycle
    p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(OFS_KEY) && bus_wdata == UNLOCK_KEY) |=> !locked_q);

    // R8: the expiry flag only rises on a non-resetting expiry
    p_flag_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(expire_ev && !rst_en));

endmodule

// File: rtl/gwdt_counter.sv
module gwdt_counter
    import guarded_wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             newload,
    input  logic             rst_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_val,
    output logic             load_done,
    output logic             expire_ev,
    output logic             rst_req
);

    wdt_state_e       st_q;
    wdt_state_e       st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;
    logic             step;

    assign at_end  = (cnt_q <= CNT_W'(1));
    assign step    = run && !newload && tick;
    assign cnt_val = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (run && newload) st_d = ST_ARM;
                else if (run)       st_d = ST_COUNT;
            end
            ST_ARM: begin
                st_d = run ? ST_COUNT : ST_IDLE;
            end
            ST_COUNT: begin
                if (!run)                        st_d = ST_IDLE;
                else if (newload)                st_d = ST_ARM;
                else if (tick && at_end && rst_en) st_d = ST_FIRED;
            end
            ST_FIRED: st_d = ST_FIRED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                ST_ARM:   cnt_q <= load_val;
                ST_COUNT: begin
                    if (step) begin
                        if (!at_end)     cnt_q <= cnt_q - CNT_W'(1);
                        else if (rst_en) cnt_q <= '0;
                        else             cnt_q <= load_val;
                    end
                end
                ST_FIRED: cnt_q <= '0;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    always_comb begin
        load_done = (st_q == ST_ARM);
        expire_ev = (st_q == ST_COUNT) && step && at_end;
        rst_req   = (st_q == ST_FIRED);
    end

    // R7: once raised, the reset request never drops before rst_n
    p_rst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R5: leaving the arm state, the counter holds the load value
    p_arm_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARM) |=> (cnt_q == $past(load_val)));

    // R6: an ordinary tick lowers the count by exactly one
    p_tick_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT && step && !at_end) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R6: a stopped counter does not move
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |=> $stable(cnt_q));

endmodule

// File: rtl/guarded_wdt.sv
module guarded_wdt
    import guarded_wdt_pkg::*;
#(
    parameter int                HALF_W     = 16,
    parameter int                ADDR_W     = 6,
    parameter logic [HALF_W-1:0] UNLOCK_KEY = 16'hE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              rst_req
);

    localparam int CNT_W = 2 * HALF_W;

    logic             run;
    logic             newload;
    logic             rst_en;
    logic             load_done;
    logic             expire_ev;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_val;

    gwdt_regs #(
        .HALF_W     (HALF_W),
        .ADDR_W     (ADDR_W),
        .UNLOCK_KEY (UNLOCK_KEY)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_val   (cnt_val),
        .load_done (load_done),
        .expire_ev (expire_ev),
        .run       (run),
        .newload   (newload),
        .rst_en    (rst_en),
        .load_val  (load_val)
    );

    gwdt_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (run),
        .newload   (newload),
        .rst_en    (rst_en),
        .load_val  (load_val),
        .cnt_val   (cnt_val),
        .load_done (load_done),
        .expire_ev (expire_ev),
        .rst_req   (rst_req)
    );

endmodule

// File: tb/guarded_wdt_tb_top.sv
module guarded_wdt_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;
    localparam logic [1:0] OP_WT = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [15:0] val;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 51;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 8'h20, 16'h0001, 4'd2},  // R2 locked after reset
        '{OP_WR, 8'h00, 16'h0005, 4'd0},
        '{OP_RD, 8'h00, 16'h0000, 4'd3},  // R3 locked write ignored
        '{OP_WR, 8'h20, 16'hE551, 4'd0},
        '{OP_RD, 8'h20, 16'h0000, 4'd2},  // R2 key opens
        '{OP_WR, 8'h00, 16'h0005, 4'd0},
        '{OP_WR, 8'h04, 16'h0000, 4'd0},
        '{OP_RD, 8'h00, 16'h0005, 4'd3},  // R3 readback
        '{OP_WR, 8'h08, 16'h0006, 4'd0},
        '{OP_WT, 8'h00, 16'd2,    4'd0},
        '{OP_RD, 8'h08, 16'h0002, 4'd5},  // R5 new-load bit self-clears
        '{OP_RD, 8'h0C, 16'h0005, 4'd5},  // R5 counter loaded
        '{OP_TK, 8'h00, 16'd3,    4'd0},
        '{OP_RD, 8'h0C, 16'h0002, 4'd6},  // R6 three ticks
        '{OP_TK, 8'h00, 16'd2,    4'd0},
        '{OP_RD, 8'h08, 16'h0012, 4'd8},  // R8 flag set, still running
        '{OP_RD, 8'h0C, 16'h0005, 4'd8},  // R8 reloaded
        '{OP_WR, 8'h08, 16'h0012, 4'd0},
        '{OP_RD, 8'h08, 16'h0002, 4'd8},  // R8 write-one clears flag
        '{OP_TK, 8'h00, 16'd2,    4'd0},
        '{OP_WR, 8'h00, 16'h0009, 4'd0},
        '{OP_WR, 8'h08, 16'h0006, 4'd0},
        '{OP_WT, 8'h00, 16'd2,    4'd0},
        '{OP_RD, 8'h0C, 16'h0009, 4'd5},  // R5 re-arm while counting
        '{OP_WR, 8'h20, 16'h1AAE, 4'd0},
        '{OP_RD, 8'h20, 16'h0001, 4'd2},  // R2 other value locks
        '{OP_WR, 8'h08, 16'h0000, 4'd0},
        '{OP_TK, 8'h00, 16'd1,    4'd0},
        '{OP_RD, 8'h0C, 16'h0008, 4'd3},  // R3 stop write ignored
        '{OP_RD, 8'h08, 16'h0002, 4'd4},  // R4 control layout
        '{OP_WR, 8'h20, 16'hE551, 4'd0},
        '{OP_WR, 8'h08, 16'h0000, 4'd0},
        '{OP_WT, 8'h00, 16'd1,    4'd0},
        '{OP_TK, 8'h00, 16'd3,    4'd0},
        '{OP_RD, 8'h0C, 16'h0008, 4'd6},  // R6 stopped counter holds
        '{OP_WR, 8'h08, 16'h0002, 4'd0},
        '{OP_WT, 8'h00, 16'd1,    4'd0},
        '{OP_TK, 8'h00, 16'd1,    4'd0},
        '{OP_RD, 8'h0C, 16'h0007, 4'd6},  // R6 resume from held value
        '{OP_WR, 8'h08, 16'h0000, 4'd0},
        '{OP_WR, 8'h00, 16'h0000, 4'd0},
        '{OP_WR, 8'h04, 16'h0001, 4'd0},
        '{OP_WR, 8'h08, 16'h0006, 4'd0},
        '{OP_WT, 8'h00, 16'd2,    4'd0},
        '{OP_RD, 8'h0C, 16'h0000, 4'd9},  // R9 low half
        '{OP_RD, 8'h10, 16'h0001, 4'd9},  // R9 high half
        '{OP_TK, 8'h00, 16'd1,    4'd0},
        '{OP_RD, 8'h0C, 16'hFFFF, 4'd9},  // R9 borrow into low half
        '{OP_RD, 8'h10, 16'h0000, 4'd9},  // R9 high half emptied
        '{OP_WR, 8'h08, 16'h0000, 4'd0},
        '{OP_WR, 8'h04, 16'h0000, 4'd0}
    };

    logic        clk;
    logic        rst_n;
    logic        tick;
    logic        bus_sel;
    logic        bus_we;
    logic [5:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        rst_req;

    int total;
    int bad;
    int cycles;

    guarded_wdt dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a[5:0]; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [15:0] exp, input int req);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a[5:0];
        #1;
        check(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic do_tick(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WD_LIMIT) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected<=%0d cycles", cycles, WD_LIMIT);
                finish_run();
            end
        end
    end

    initial begin
        total = 0; bad = 0;
        rst_n = 1'b0; tick = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state at the ports
        #1;
        check(1, 16'(rst_req), 16'h0);
        do_rd(8'h20, 16'h0001, 1);
        do_rd(8'h08, 16'h0000, 1);
        do_rd(8'h0C, 16'h0000, 1);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR:   do_wr(VEC[i].addr, VEC[i].val);
                OP_RD:   do_rd(VEC[i].addr, VEC[i].val, int'(VEC[i].req));
                OP_TK:   do_tick(int'(VEC[i].val));
                default: do_wait(int'(VEC[i].val));
            endcase
        end

        // R7 expiry with reset enabled: load 3, three ticks
        do_wr(8'h00, 16'h0003);
        do_wr(8'h08, 16'h000E);
        do_wait(2);
        #1 check(7, 16'(rst_req), 16'h0);
        do_tick(2);
        #1 check(7, 16'(rst_req), 16'h0);
        do_tick(1);
        #1 check(7, 16'(rst_req), 16'h1);
        do_wr(8'h08, 16'h0000);
        do_tick(2);
        do_wait(3);
        #1 check(7, 16'(rst_req), 16'h1);
        do_rd(8'h0C, 16'h0000, 7);

        // R1 block reset clears the request and reinstates defaults
        @(negedge clk);
        rst_n = 1'b0;
        do_wait(2);
        rst_n = 1'b1;
        #1 check(1, 16'(rst_req), 16'h0);
        do_rd(8'h20, 16'h0001, 1);
        do_rd(8'h00, 16'h0000, 1);
        do_rd(8'h08, 16'h0000, 1);

        finish_run();
    end

endmodule